// File: doc/BRIEF.md
# Channel Interrupt Status Controller

This block keeps one pending-interrupt flag for each of sixteen channels, plus a sixteen-bit enable mask, behind a simple synchronous register bus. A channel's event input is a one-cycle pulse that sets that channel's flag. Where a pending flag meets a set enable bit, a per-channel request goes out, and a registered OR of all requests forms the combined interrupt line.

Clearing a flag is interlocked. Each read of the status register records which of the returned bits were 1, per byte lane, in an "armed" mask. A later write of zero clears a flag only if that flag is armed. Every write to the status register then disarms the lanes it touched. An event that arrives on an armed channel disarms that channel, so the event survives a clearing write that was issued before software could have seen it.

Both registers accept 16-bit accesses and byte-wide accesses to either half. The status register is at byte offset 0x0 and the enable register is at byte offset 0x2. A cycle that carries both strobes is treated as a write only.

Top module: `chan_irq_status_ctrl`

## Requirements
- R1: After reset, all flags, all enables, the armed mask, `bus_rdata`, `chan_irq` and `irq_any` are zero.
- R2: A 1 on `chan_event[i]` sets flag i at the next clock edge. Bit i of status read data is channel i, so bit 15 is channel 15.
- R3: Writing 1 to a status bit does nothing. Writing 0 to a flag whose lane has not been read since the last status write (or whose last read returned 0) leaves the flag set.
- R4: A status read that returns flag i as 1, followed by a status write with bit i equal to 0 and its lane enabled, clears flag i. Flags change in no other way than by events and such writes.
- R5: If an event on channel i arrives in the same cycle as a qualifying clear, or in any cycle between the arming read and the clearing write, flag i is still set after the write.
- R6: Any status write disarms all bits in its enabled lanes. A second write of 0 with no new read in between therefore clears nothing.
- R7: Byte lane enable bit 0 covers data bits 7:0, and enable bit 1 covers data bits 15:8. A status read arms only its enabled lanes, and a status write clears and disarms only its enabled lanes.
- R8: The enable register at offset 0x2 is written per enabled byte lane, keeps its value when not written, and reads back in full.
- R9: `chan_irq[i]` is high exactly while flag i and enable bit i are both 1.
- R10: `irq_any` equals the OR of `chan_irq`, delayed by one clock.
- R11: `bus_rdata` loads the addressed register one clock after a read strobe. It reads zero for unmapped offsets and holds its value in cycles without a read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | ADDR_W | Byte address of the register |
| bus_rd | input | 1 | Read strobe |
| bus_wr | input | 1 | Write strobe |
| bus_be | input | DATA_W/8 | Byte lane enables |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Registered read data |
| chan_event | input | N_CH | Per-channel one-cycle event pulses |
| chan_irq | output | N_CH | Per-channel interrupt requests |
| irq_any | output | 1 | Registered combined interrupt request |

## Verification
The bench builds the block with its defaults: sixteen channels, two byte lanes, a two-bit address and the registered combined output. Two lanes are enough to show one lane being cleared while the other is left untouched. The two-bit address also reaches the unmapped offsets 1 and 3. The registered output lets the bench check the one-clock lag of `irq_any` against a delayed copy of the per-channel requests. Random traffic with sparse events brings about the event-versus-clear races and the reads that arm some bits but not others.

// File: rtl/cisc_pkg.sv
package cisc_pkg;
   localparam int STAT_OFS = 0;
   localparam int EN_OFS   = 2;
   localparam int LANE_W   = 8;
endpackage

// File: rtl/cisc_status_bank.sv
module cisc_status_bank
   import cisc_pkg::*;
#(
   parameter int N_CH  = 16,
   parameter int LANES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             rd_stb,
   input  logic             wr_stb,
   input  logic [LANES-1:0] be,
   input  logic [N_CH-1:0]  wdata,
   input  logic [N_CH-1:0]  event_in,
   output logic [N_CH-1:0]  flags
);
   localparam int DW = LANES * LANE_W;

   if (DW != N_CH) begin : g_bad_width
      $error("cisc_status_bank: N_CH must equal LANES*8");
   end

   logic [N_CH-1:0] flag_q, arm_q, arm_d, lmask, clr;

   for (genvar l = 0; l < LANES; l++) begin : g_lane
      assign lmask[l*LANE_W +: LANE_W] = {LANE_W{be[l]}};
   end

   assign clr = wr_stb ? (~wdata & arm_q & lmask) : '0;

   always_comb begin
      arm_d = arm_q;
      if (rd_stb) arm_d = (flag_q & lmask) | (arm_q & ~lmask);
      if (wr_stb) arm_d = arm_d & ~lmask;
      arm_d = arm_d & ~event_in;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         flag_q <= '0;
         arm_q  <= '0;
      end else begin
         flag_q <= (flag_q & ~clr) | event_in;
         arm_q  <= arm_d;
      end
   end

   assign flags = flag_q;

   // R2 / R5: an event always leaves its flag set
   a_r5_event_wins: assert property (@(posedge clk) disable iff (!rst_n)
      (|event_in) |=> ((flag_q & $past(event_in)) == $past(event_in)));
   // R3: a flag that was not armed never drops
   a_r3_unarmed_kept: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> (($past(flag_q) & ~$past(arm_q) & ~flag_q) == '0));
   // R4: flags fall only on a status write
   a_r4_fall_needs_write: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_stb |=> (($past(flag_q) & ~flag_q) == '0));
   // R6: a write leaves its lanes disarmed
   a_r6_arm_dropped: assert property (@(posedge clk) disable iff (!rst_n)
      wr_stb |=> ((arm_q & $past(lmask)) == '0));
   // R7: disabled lanes keep their flags through a write
   a_r7_lane_isolated: assert property (@(posedge clk) disable iff (!rst_n)
      wr_stb |=> (($past(flag_q) & ~$past(lmask) & ~flag_q) == '0));
endmodule

// File: rtl/cisc_enable_reg.sv
module cisc_enable_reg
   import cisc_pkg::*;
#(
   parameter int LANES = 2
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    wr_stb,
   input  logic [LANES-1:0]        be,
   input  logic [LANES*LANE_W-1:0] wdata,
   output logic [LANES*LANE_W-1:0] en
);
   logic [LANES*LANE_W-1:0] en_q;

   for (genvar l = 0; l < LANES; l++) begin : g_lane
      always_ff @(posedge clk) begin
         if (!rst_n)
            en_q[l*LANE_W +: LANE_W] <= '0;
         else if (wr_stb && be[l])
            en_q[l*LANE_W +: LANE_W] <= wdata[l*LANE_W +: LANE_W];
      end
   end

   assign en = en_q;

   // R8: the mask holds when not written
   a_r8_en_holds: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_stb |=> $stable(en_q));
endmodule

// File: rtl/cisc_irq_merge.sv
module cisc_irq_merge #(
   parameter int N_CH    = 16,
   parameter bit IRQ_REG = 1'b1
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [N_CH-1:0] flags,
   input  logic [N_CH-1:0] en,
   output logic [N_CH-1:0] chan_irq,
   output logic            irq_any
);
   assign chan_irq = flags & en;

   if (IRQ_REG) begin : g_reg
      logic any_q;
      always_ff @(posedge clk) begin
         if (!rst_n) any_q <= 1'b0;
         else        any_q <= |chan_irq;
      end
      assign irq_any = any_q;

      // R10: combined line lags the per-channel requests by one clock
      a_r10_any_lag: assert property (@(posedge clk) disable iff (!rst_n)
         1'b1 |=> (irq_any == $past(|chan_irq)));
   end else begin : g_comb
      assign irq_any = |chan_irq;
   end

   // R9: no request without an enable bit
   a_r9_req_needs_en: assert property (@(posedge clk) disable iff (!rst_n)
      ((chan_irq & ~en) == '0));
endmodule

// File: rtl/chan_irq_status_ctrl.sv
module chan_irq_status_ctrl
   import cisc_pkg::*;
#(
   parameter int N_CH    = 16,
   parameter int DATA_W  = 16,
   parameter int ADDR_W  = 2,
   parameter bit IRQ_REG = 1'b1
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic [ADDR_W-1:0]     bus_addr,
   input  logic                  bus_rd,
   input  logic                  bus_wr,
   input  logic [DATA_W/8-1:0]   bus_be,
   input  logic [DATA_W-1:0]     bus_wdata,
   output logic [DATA_W-1:0]     bus_rdata,
   input  logic [N_CH-1:0]       chan_event,
   output logic [N_CH-1:0]       chan_irq,
   output logic                  irq_any
);
   localparam int LANES = DATA_W / LANE_W;

   if (DATA_W % LANE_W != 0) begin : g_bad_dw
      $error("chan_irq_status_ctrl: DATA_W must be a multiple of 8");
   end
   if (N_CH != DATA_W) begin : g_bad_ch
      $error("chan_irq_status_ctrl: N_CH must equal DATA_W");
   end
   if (ADDR_W < 2) begin : g_bad_aw
      $error("chan_irq_status_ctrl: ADDR_W must reach offset 2");
   end

   logic sel_stat, sel_en, rd_eff;
   logic [N_CH-1:0]   flags;
   logic [DATA_W-1:0] en;
   logic [DATA_W-1:0] rdata_q;

   assign sel_stat = (bus_addr == ADDR_W'(STAT_OFS));
   assign sel_en   = (bus_addr == ADDR_W'(EN_OFS));
   assign rd_eff   = bus_rd && !bus_wr;

   cisc_status_bank #(.N_CH(N_CH), .LANES(LANES)) u_stat (
      .clk      (clk),
      .rst_n    (rst_n),
      .rd_stb   (rd_eff && sel_stat),
      .wr_stb   (bus_wr && sel_stat),
      .be       (bus_be),
      .wdata    (bus_wdata),
      .event_in (chan_event),
      .flags    (flags)
   );

   cisc_enable_reg #(.LANES(LANES)) u_en (
      .clk    (clk),
      .rst_n  (rst_n),
      .wr_stb (bus_wr && sel_en),
      .be     (bus_be),
      .wdata  (bus_wdata),
      .en     (en)
   );

   cisc_irq_merge #(.N_CH(N_CH), .IRQ_REG(IRQ_REG)) u_irq (
      .clk      (clk),
      .rst_n    (rst_n),
      .flags    (flags),
      .en       (en),
      .chan_irq (chan_irq),
      .irq_any  (irq_any)
   );

   always_ff @(posedge clk) begin
      if (!rst_n)
         rdata_q <= '0;
      else if (rd_eff)
         rdata_q <= sel_stat ? flags : (sel_en ? en : '0);
   end

   assign bus_rdata = rdata_q;

   // R11: read data holds in cycles without a read
   a_r11_rdata_holds: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_eff |=> $stable(bus_rdata));
endmodule

// File: tb/chan_irq_status_ctrl_tb.sv
module chan_irq_status_ctrl_tb_top;
   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [1:0]  bus_addr = '0;
   logic        bus_rd = 1'b0;
   logic        bus_wr = 1'b0;
   logic [1:0]  bus_be = '0;
   logic [15:0] bus_wdata = '0;
   logic [15:0] bus_rdata;
   logic [15:0] chan_event = '0;
   logic [15:0] chan_irq;
   logic        irq_any;

   always #(CLK_PERIOD/2) clk = ~clk;

   chan_irq_status_ctrl dut_i (
      .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_rd(bus_rd),
      .bus_wr(bus_wr), .bus_be(bus_be), .bus_wdata(bus_wdata),
      .bus_rdata(bus_rdata), .chan_event(chan_event),
      .chan_irq(chan_irq), .irq_any(irq_any)
   );

   int n_chk = 0;
   int n_bad = 0;

   // bench model
   logic [15:0] mf = '0, marm = '0, men = '0, mrd = '0;
   logic        many = 1'b0;

   function automatic logic [15:0] lanes(input logic [1:0] be);
      return {{8{be[1]}}, {8{be[0]}}};
   endfunction

   function automatic logic [15:0] rd_value(input logic [1:0] a,
                                            input logic [15:0] f,
                                            input logic [15:0] e);
      if (a == 2'd0) return f;
      if (a == 2'd2) return e;
      return '0;
   endfunction

   task automatic check(input bit ok, input string req,
                        input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic model_step(input logic rd, input logic wr, input logic [1:0] a,
                             input logic [1:0] be, input logic [15:0] wd,
                             input logic [15:0] ev);
      logic [15:0] lm, clr, arm_n;
      logic        prev;
      prev  = |(mf & men);
      lm    = lanes(be);
      clr   = '0;
      arm_n = marm;
      if (rd && !wr) begin
         mrd = rd_value(a, mf, men);
         if (a == 2'd0) arm_n = (mf & lm) | (marm & ~lm);
      end
      if (wr && a == 2'd0) begin
         clr   = ~wd & marm & lm;
         arm_n = arm_n & ~lm;
      end
      if (wr && a == 2'd2) men = (men & ~lm) | (wd & lm);
      mf   = (mf & ~clr) | ev;
      marm = arm_n & ~ev;
      many = prev;
   endtask

   task automatic cyc(input logic rd, input logic wr, input logic [1:0] a,
                      input logic [1:0] be, input logic [15:0] wd,
                      input logic [15:0] ev);
      @(negedge clk);
      bus_rd = rd; bus_wr = wr; bus_addr = a; bus_be = be;
      bus_wdata = wd; chan_event = ev;
      @(posedge clk);
      #1;
      model_step(rd, wr, a, be, wd, ev);
      bus_rd = 1'b0; bus_wr = 1'b0; chan_event = '0;
      check(chan_irq == (mf & men), "R9 chan_irq", 32'(chan_irq), 32'(mf & men));
      check(irq_any == many, "R10 irq_any", 32'(irq_any), 32'(many));
      check(bus_rdata == mrd, "R11 rdata", 32'(bus_rdata), 32'(mrd));
   endtask

   task automatic rd_reg(input logic [1:0] a, input logic [1:0] be);
      cyc(1'b1, 1'b0, a, be, '0, '0);
   endtask

   task automatic wr_reg(input logic [1:0] a, input logic [1:0] be,
                         input logic [15:0] d, input logic [15:0] ev);
      cyc(1'b0, 1'b1, a, be, d, ev);
   endtask

   task automatic idle(input logic [15:0] ev);
      cyc(1'b0, 1'b0, 2'd0, 2'b00, '0, ev);
   endtask

   task automatic summary();
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=%h expected=%h", 32'd1, 32'd0);
      summary();
   end

   initial begin
      void'($urandom(32'd4242));
      repeat (3) @(posedge clk);
      #1;
      // R1: reset state
      check(chan_irq == 16'h0, "R1 chan_irq", 32'(chan_irq), 32'h0);
      check(irq_any == 1'b0, "R1 irq_any", 32'(irq_any), 32'h0);
      check(bus_rdata == 16'h0, "R1 rdata", 32'(bus_rdata), 32'h0);
      @(negedge clk);
      rst_n = 1'b1;
      rd_reg(2'd0, 2'b11);
      check(bus_rdata == 16'h0, "R1 status zero", 32'(bus_rdata), 32'h0);
      rd_reg(2'd2, 2'b11);
      check(bus_rdata == 16'h0, "R1 enable zero", 32'(bus_rdata), 32'h0);

      // R8: enable register, byte writes
      wr_reg(2'd2, 2'b01, 16'hA5C3, '0);
      rd_reg(2'd2, 2'b11);
      check(bus_rdata == 16'h00C3, "R8 low lane", 32'(bus_rdata), 32'h00C3);
      wr_reg(2'd2, 2'b10, 16'hFF00, '0);
      rd_reg(2'd2, 2'b11);
      check(bus_rdata == 16'hFFC3, "R8 high lane", 32'(bus_rdata), 32'hFFC3);
      wr_reg(2'd2, 2'b11, 16'hFFFF, '0);

      // R2: event on channel 15 lands in bit 15
      idle(16'h8000);
      check(chan_irq == 16'h8000, "R2 ch15 flag", 32'(chan_irq), 32'h8000);
      idle('0);
      check(irq_any == 1'b1, "R10 any after lag", 32'(irq_any), 32'h1);

      // R3: write zero without a read keeps the flag; write one does nothing
      wr_reg(2'd0, 2'b11, 16'h0000, '0);
      check(chan_irq == 16'h8000, "R3 unarmed zero", 32'(chan_irq), 32'h8000);
      rd_reg(2'd0, 2'b11);
      wr_reg(2'd0, 2'b11, 16'hFFFF, '0);
      check(chan_irq == 16'h8000, "R3 write one", 32'(chan_irq), 32'h8000);

      // R6: the previous write disarmed; zero now clears nothing
      wr_reg(2'd0, 2'b11, 16'h0000, '0);
      check(chan_irq == 16'h8000, "R6 disarmed", 32'(chan_irq), 32'h8000);

      // R4: read then clear
      rd_reg(2'd0, 2'b11);
      check(bus_rdata == 16'h8000, "R4 read set", 32'(bus_rdata), 32'h8000);
      wr_reg(2'd0, 2'b11, 16'h0000, '0);
      check(chan_irq == 16'h0000, "R4 cleared", 32'(chan_irq), 32'h0);

      // R5: event in the same cycle as the clear
      idle(16'h0010);
      rd_reg(2'd0, 2'b11);
      wr_reg(2'd0, 2'b11, 16'h0000, 16'h0010);
      check(chan_irq == 16'h0010, "R5 same cycle", 32'(chan_irq), 32'h0010);
      // R5: event between the read and the clear
      rd_reg(2'd0, 2'b11);
      idle(16'h0010);
      wr_reg(2'd0, 2'b11, 16'h0000, '0);
      check(chan_irq == 16'h0010, "R5 between", 32'(chan_irq), 32'h0010);
      rd_reg(2'd0, 2'b11);
      wr_reg(2'd0, 2'b11, 16'h0000, '0);
      check(chan_irq == 16'h0000, "R4 later clear", 32'(chan_irq), 32'h0);

      // R7: lane-limited clears
      idle(16'h0404);
      rd_reg(2'd0, 2'b11);
      wr_reg(2'd0, 2'b01, 16'h0000, '0);
      check(chan_irq == 16'h0400, "R7 low lane cleared", 32'(chan_irq), 32'h0400);
      idle(16'h0004);
      rd_reg(2'd0, 2'b10);
      wr_reg(2'd0, 2'b11, 16'h0000, '0);
      check(chan_irq == 16'h0004, "R7 only high armed", 32'(chan_irq), 32'h0004);

      // R11: unmapped offset reads zero, then holds
      rd_reg(2'd1, 2'b11);
      check(bus_rdata == 16'h0000, "R11 unmapped", 32'(bus_rdata), 32'h0);
      idle('0);
      check(bus_rdata == 16'h0000, "R11 hold", 32'(bus_rdata), 32'h0);

      // random traffic against the model
      for (int i = 0; i < 1500; i++) begin
         int unsigned op;
         logic [15:0] ev;
         op = $urandom_range(0, 9);
         ev = 16'($urandom & $urandom & $urandom & $urandom);
         case (op)
            0, 1, 2: cyc(1'b1, 1'b0, 2'd0, 2'($urandom), '0, ev);
            3, 4:    cyc(1'b0, 1'b1, 2'd0, 2'($urandom), 16'($urandom), ev);
            5:       cyc(1'b0, 1'b1, 2'd2, 2'($urandom), 16'($urandom), ev);
            6:       cyc(1'b1, 1'b0, 2'($urandom), 2'b11, '0, ev);
            7:       cyc(1'b1, 1'b1, 2'd0, 2'b11, 16'($urandom), ev);
            default: idle(ev);
         endcase
      end
      summary();
   end
endmodule